// File: doc/BRIEF.md
# Two-Wire Serial Debug Read Slave

This block is the slave end of a two-wire debug link. The link has one serial clock line and one data line. The external master owns the clock. Toward the slave it drives the data line. The slave answers on a split output: a data bit plus an output enable, which the pad ring combines into the shared line.

A transaction opens with a start condition. The master then shifts in a 7-bit register address and a direction bit. One separator clock follows. On a read, the slave then streams register bytes, most significant bit first. Each byte is followed by one separator clock, so one byte takes nine serial clocks. The register address advances after every byte until it reaches 0x20, the top of the read-only space. From there every further byte repeats that register. A stop condition ends the stream.

The serial lines pass through a synchronizer into the system clock domain. Registers are fetched through a synchronous read port: the address goes out with a one-cycle read strobe, and the data returns on the next clock. Each serial half-period must last at least eight system clocks.

The controller is a state machine with six states:
- IDLE waits for a start condition.
- ADDR shifts in the eight header bits.
- ASEP covers the separator clock after the header.
- DATA shifts out one byte.
- DSEP covers the separator clock after each byte.
- SKIP ignores everything after a write header.

It has these transitions:
- A start condition moves any state to ADDR.
- A stop condition moves any state to IDLE.
- ADDR moves to ASEP when the eighth header bit is 1, and to SKIP when it is 0.
- ASEP and DSEP move to DATA on the falling clock edge that ends the separator.
- DATA moves to DSEP on the falling clock edge of its eighth bit.

Top module: `dbg_rd_slave`

## Requirements
- R1: After reset, `ser_oe` is 0, `rf_re` is 0 and `rf_addr` is 0.
- R2: A start condition is a falling edge on `ser_din` while `ser_clk` is high. The header follows it: seven address bits sampled on rising clock edges, most significant first, then a direction bit. A direction bit of 1 means read and 0 means write. The first byte returned comes from the register at the received address.
- R3: `ser_oe` is 0 in three places: during the header, during the separator clock that follows the header, and during the separator clock that follows every byte.
- R4: Data bits change on falling clock edges and are valid at the next rising edge, D7 first and D0 last. Exactly one separator clock lies between the header and the first data bit. Each byte occupies nine serial clocks.
- R5: During a block read, `rf_addr` advances by one after each byte for as long as the master keeps clocking.
- R6: The address stops advancing once it is 0x20 or above. Later bytes repeat the register at that address. A read that starts above 0x20 returns the same register every time.
- R7: After a write header (direction bit 0), the slave never raises `ser_oe` and never issues `rf_re` until the next start condition.
- R8: A start condition in the middle of a transaction discards the partial header and begins a new address phase.
- R9: A stop condition is a rising edge on `ser_din` while `ser_clk` is high. It ends a block read. After it, `ser_oe` stays 0 and no further `rf_re` is issued while the clock keeps toggling.
- R10: During each separator clock, `rf_re` pulses for exactly one system clock while `ser_oe` is 0. There is one pulse per byte. The next byte is loaded into the shift register at the falling edge that ends the separator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the master |
| ser_din | input | 1 | Data line as seen by the slave (master drive) |
| ser_dout | output | 1 | Data bit the slave presents on the line |
| ser_oe | output | 1 | High while the slave drives the data line |
| rf_addr | output | 7 | Register file read address |
| rf_re | output | 1 | One-cycle register read strobe |
| rf_rdata | input | 8 | Register data, valid one clock after `rf_re` |

## Verification
Some properties are checked on every cycle:
- The output enable is high only in DATA.
- A read strobe lasts one cycle and never coincides with a driven line.
- No strobe is issued in SKIP.
- The address counter either steps by one below 0x20 or holds at or above it.

Only the directed scenarios can show the rest, because it depends on the serial order of events across many clocks:
- the bit order of the header and of the data;
- the nine-clock byte framing;
- which register each streamed byte comes from, including the repeat at 0x20;
- the effect of start and stop conditions in the middle of a transaction.

// File: rtl/dbg_rd_pkg.sv
package dbg_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ASEP,
        ST_DATA,
        ST_DSEP,
        ST_SKIP
    } rd_state_e;
endpackage

// File: rtl/dbg_line_sync.sv
module dbg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_din,
    output logic din_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] din_pipe;
    logic              sck_d;
    logic              din_d;
    logic              sck_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_pipe <= '1;
                    din_pipe <= '1;
                end else begin
                    sck_pipe <= ser_clk;
                    din_pipe <= ser_din;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_pipe <= '1;
                    din_pipe <= '1;
                end else begin
                    sck_pipe <= {sck_pipe[STAGES-2:0], ser_clk};
                    din_pipe <= {din_pipe[STAGES-2:0], ser_din};
                end
            end
        end
    endgenerate

    assign sck_s = sck_pipe[STAGES-1];
    assign din_s = din_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b1;
            din_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            din_d <= din_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign start_ev = sck_s & sck_d & din_d & ~din_s;
    assign stop_ev  = sck_s & sck_d & ~din_d & din_s;
endmodule

// File: rtl/dbg_addr_ctr.sv
module dbg_addr_ctr #(
    parameter int AW       = 7,
    parameter int SAT_ADDR = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] SAT = AW'(SAT_ADDR);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (adv && (addr_q < SAT)) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;

    // R5
    step_below_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && (addr_q < SAT)) |=> (addr_q == $past(addr_q) + 1'b1));

    // R6
    hold_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && (addr_q >= SAT)) |=> $stable(addr_q));
endmodule

// File: rtl/dbg_tx_shift.sv
module dbg_tx_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          shift,
    output logic          dout
);
    logic [DW-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else if (load) begin
            sh_q <= load_val;
        end else if (shift) begin
            sh_q <= {sh_q[DW-2:0], 1'b1};
        end
    end

    assign dout = sh_q[DW-1];
endmodule

// File: rtl/dbg_rd_slave.sv
module dbg_rd_slave
    import dbg_rd_pkg::*;
#(
    parameter int AW          = 7,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SAT_ADDR    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk,
    input  logic          ser_din,
    output logic          ser_dout,
    output logic          ser_oe,
    output logic [AW-1:0] rf_addr,
    output logic          rf_re,
    input  logic [DW-1:0] rf_rdata
);
    localparam int HDR_BITS = AW + 1;
    localparam int CW = $clog2((HDR_BITS > DW) ? HDR_BITS : DW);
    localparam logic [CW-1:0] HDR_LAST  = CW'(HDR_BITS - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(DW - 1);

    logic          din_s, sck_rise, sck_fall, start_ev, stop_ev;
    rd_state_e     state_q, state_d;
    logic [CW-1:0] bitcnt_q;
    logic [AW-1:0] hdr_q;
    logic          sep_rose_q;
    logic          rd_pend_q;
    logic [DW-1:0] hold_q;
    logic          oe_q;
    logic          re_q;

    logic ctr_load, ctr_adv, sh_load, sh_shift, re_d, oe_set, oe_clr;

    dbg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_din  (ser_din),
        .din_s    (din_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    dbg_addr_ctr #(.AW(AW), .SAT_ADDR(SAT_ADDR)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (hdr_q),
        .adv      (ctr_adv),
        .addr     (rf_addr)
    );

    dbg_tx_shift #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (hold_q),
        .shift    (sh_shift),
        .dout     (ser_dout)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d  = state_q;
        ctr_load = 1'b0;
        ctr_adv  = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        re_d     = 1'b0;
        oe_set   = 1'b0;
        oe_clr   = 1'b0;
        if (stop_ev) begin
            state_d = ST_IDLE;
            oe_clr  = 1'b1;
        end else if (start_ev) begin
            state_d = ST_ADDR;
            oe_clr  = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (sck_rise && (bitcnt_q == HDR_LAST)) begin
                        ctr_load = 1'b1;
                        state_d  = din_s ? ST_ASEP : ST_SKIP;
                    end
                end
                ST_ASEP, ST_DSEP: begin
                    if (sck_rise && !sep_rose_q) begin
                        re_d = 1'b1;
                    end else if (sck_fall && sep_rose_q) begin
                        sh_load = 1'b1;
                        oe_set  = 1'b1;
                        state_d = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (sck_fall) begin
                        if (bitcnt_q == DATA_LAST) begin
                            oe_clr  = 1'b1;
                            ctr_adv = 1'b1;
                            state_d = ST_DSEP;
                        end else begin
                            sh_shift = 1'b1;
                        end
                    end
                end
                ST_SKIP: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q   <= '0;
            hdr_q      <= '0;
            sep_rose_q <= 1'b0;
            rd_pend_q  <= 1'b0;
            hold_q     <= '0;
            oe_q       <= 1'b0;
            re_q       <= 1'b0;
        end else begin
            re_q      <= re_d;
            rd_pend_q <= re_q;
            if (rd_pend_q) hold_q <= rf_rdata;

            if (oe_clr)      oe_q <= 1'b0;
            else if (oe_set) oe_q <= 1'b1;

            if (start_ev || stop_ev || sh_load) sep_rose_q <= 1'b0;
            else if (re_d)                      sep_rose_q <= 1'b1;

            if (start_ev || sh_load) begin
                bitcnt_q <= '0;
            end else if (state_q == ST_ADDR && sck_rise) begin
                bitcnt_q <= bitcnt_q + 1'b1;
                hdr_q    <= {hdr_q[AW-2:0], din_s};
            end else if (sh_shift) begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end
        end
    end

    assign ser_oe = oe_q;
    assign rf_re  = re_q;

    // R3
    quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DATA) |-> !ser_oe);

    // R4
    data_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> ser_oe);

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |=> !rf_re);

    // R10
    strobe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |-> !ser_oe);

    // R7
    skip_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !rf_re);
endmodule

// File: tb/dbg_rd_slave_bench.sv
module dbg_rd_slave_bench;
    localparam int  HALF = 8;
    localparam logic [6:0] TOP = 7'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_m = 1'b1;
    logic       din_m = 1'b1;
    logic       ser_dout, ser_oe, rf_re;
    logic [6:0] rf_addr;
    logic [7:0] rf_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int re_cnt = 0;
    int re_oe_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_rd_slave u_dbg_rd_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (sck_m),
        .ser_din  (din_m),
        .ser_dout (ser_dout),
        .ser_oe   (ser_oe),
        .rf_addr  (rf_addr),
        .rf_re    (rf_re),
        .rf_rdata (rf_rdata)
    );

    function automatic logic [7:0] reg_val(input logic [6:0] a);
        return 8'((a * 37) + 90) ^ {a, 1'b1};
    endfunction

    always_ff @(posedge clk) begin
        if (rf_re) rf_rdata <= reg_val(rf_addr);
    end

    always @(negedge clk) begin
        if (rf_re) begin
            re_cnt++;
            if (ser_oe) re_oe_cnt++;
        end
    end

    task automatic chk(input bit ok, input string rid, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rid, act, exp);
        end
    endtask

    task automatic bit_xfer(input logic d, output logic q, output logic oe);
        sck_m = 1'b0;
        din_m = d;
        repeat (HALF) @(negedge clk);
        q  = ser_dout;
        oe = ser_oe;
        sck_m = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic do_start();
        sck_m = 1'b0;
        din_m = 1'b1;
        repeat (HALF) @(negedge clk);
        sck_m = 1'b1;
        repeat (HALF) @(negedge clk);
        din_m = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic do_stop();
        sck_m = 1'b0;
        din_m = 1'b0;
        repeat (HALF) @(negedge clk);
        sck_m = 1'b1;
        repeat (HALF) @(negedge clk);
        din_m = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    // Header plus the following separator; returns whether oe was ever seen high
    task automatic send_hdr(input logic [6:0] a, input logic rw, output logic oe_seen);
        logic q, oe;
        oe_seen = 1'b0;
        for (int i = 6; i >= 0; i--) begin
            bit_xfer(a[i], q, oe);
            oe_seen |= oe;
        end
        bit_xfer(rw, q, oe);
        oe_seen |= oe;
        bit_xfer(1'b1, q, oe);
        oe_seen |= oe;
    endtask

    task automatic read_stream(input logic [6:0] a0, input int nbytes, input string rid);
        logic [6:0] a;
        logic [7:0] got;
        logic q, oe, oe_hdr, oe_all, oe_sep;
        a = a0;
        send_hdr(a0, 1'b1, oe_hdr);
        chk(!oe_hdr, "R3 header released", int'(oe_hdr), 0);
        for (int k = 0; k < nbytes; k++) begin
            oe_all = 1'b1;
            for (int b = 7; b >= 0; b--) begin
                bit_xfer(1'b1, q, oe);
                got[b] = q;
                oe_all &= oe;
            end
            bit_xfer(1'b1, q, oe_sep);
            chk(got == reg_val(a), rid, int'(got), int'(reg_val(a)));
            chk(oe_all && !oe_sep, "R3 drive window", int'({oe_all, oe_sep}), 2);
            if (a < TOP) a = a + 1'b1;
        end
    endtask

    task automatic t_reset();
        // R1
        chk(!ser_oe, "R1 oe", int'(ser_oe), 0);
        chk(!rf_re, "R1 re", int'(rf_re), 0);
        chk(rf_addr == 7'h0, "R1 addr", int'(rf_addr), 0);
    endtask

    task automatic t_single();
        // R2 R4 single byte, then R5 address step
        do_start();
        read_stream(7'h05, 1, "R2 single byte");
        do_stop();
        chk(rf_addr == 7'h06, "R5 step after byte", int'(rf_addr), 6);
    endtask

    task automatic t_block();
        int re0;
        re0 = re_cnt;
        do_start();
        read_stream(7'h10, 5, "R5 block byte");
        do_stop();
        // R10: one strobe per byte, plus the one fetched before the stop
        chk(re_cnt - re0 == 6, "R10 strobe count", re_cnt - re0, 6);
        chk(re_oe_cnt == 0, "R10 strobe while released", re_oe_cnt, 0);
    endtask

    task automatic t_saturate();
        do_start();
        read_stream(7'h1D, 7, "R6 saturating byte");
        do_stop();
        chk(rf_addr == TOP, "R6 held at top", int'(rf_addr), int'(TOP));
        do_start();
        read_stream(7'h45, 3, "R6 above top");
        do_stop();
        chk(rf_addr == 7'h45, "R6 above top held", int'(rf_addr), 'h45);
    endtask

    task automatic t_write();
        int re0;
        logic q, oe, oe_any;
        re0 = re_cnt;
        do_start();
        send_hdr(7'h03, 1'b0, oe_any);
        for (int i = 0; i < 18; i++) begin
            bit_xfer(logic'(i % 3 == 0), q, oe);
            oe_any |= oe;
        end
        do_stop();
        // R7
        chk(!oe_any, "R7 write never drives", int'(oe_any), 0);
        chk(re_cnt == re0, "R7 write no read", re_cnt - re0, 0);
    endtask

    task automatic t_restart();
        logic q, oe;
        do_start();
        bit_xfer(1'b1, q, oe);
        bit_xfer(1'b1, q, oe);
        bit_xfer(1'b0, q, oe);
        do_start();
        // R8
        read_stream(7'h0A, 2, "R8 restart byte");
        do_stop();
    endtask

    task automatic t_stop();
        int re0;
        logic q, oe, oe_any;
        do_start();
        read_stream(7'h08, 2, "R9 pre-stop byte");
        do_stop();
        re0 = re_cnt;
        oe_any = 1'b0;
        for (int i = 0; i < 9; i++) begin
            bit_xfer(1'b1, q, oe);
            oe_any |= oe;
        end
        // R9
        chk(!oe_any && !ser_oe, "R9 released after stop", int'(oe_any), 0);
        chk(re_cnt == re0, "R9 no read after stop", re_cnt - re0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_single();
        t_block();
        t_saturate();
        t_write();
        t_restart();
        t_stop();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule